// File: doc/BRIEF.md
# Programming pin state port

This block lets a host drive a small group of device-programming pins straight from an 8-bit state word, and read back two input pins. It drives six output pins: a test clock, a mode select, a data line, two active-low serial-flash selects (chip enable and chip select), and an indicator line. The indicator line also serves as the output enable. One command sets all six outputs at once. A command flagged as a read also returns the two sampled input pins, the device data line and the serial-flash data line, once the new outputs are in place.

The block owns one shared enable for every output pad. When the host clears the enable bit, the pads are released before any output value moves. When the host sets it, the new values are placed first and the pads are driven only after that. A five-state sequencer enforces this order.

States:
- ST_IDLE: ready for a command.
- ST_PADS_OFF: release the pads.
- ST_DRIVE: load the pin registers.
- ST_PADS_ON: drive the pads.
- ST_CAPTURE: sample the inputs and pulse the response.

Transitions:
- accept-off: ST_IDLE to ST_PADS_OFF, on an accepted command with the enable bit clear.
- accept-on: ST_IDLE to ST_DRIVE, on an accepted command with the enable bit set.
- release-done: ST_PADS_OFF to ST_DRIVE.
- drive-to-on: ST_DRIVE to ST_PADS_ON, when the enable bit is set.
- drive-to-capture: ST_DRIVE to ST_CAPTURE, when the enable bit is clear and the command is a read.
- drive-done: ST_DRIVE to ST_IDLE, when the enable bit is clear and the command is a write.
- on-to-capture: ST_PADS_ON to ST_CAPTURE, for a read.
- on-done: ST_PADS_ON to ST_IDLE, for a write.
- capture-done: ST_CAPTURE to ST_IDLE.

Top module: `pinport_top`

## Requirements
- R1: After reset, all six pin outputs are 0, `pad_oe_o` is 0, `rsp_valid` is 0 and `cmd_ready` is 1.
- R2: The command byte maps onto the pins as follows:
  - bit 0 drives `pin_clk_o`
  - bit 1 drives `pin_mode_o`
  - bit 2 drives `pin_ce_n_o`
  - bit 3 drives `pin_cs_n_o`
  - bit 4 drives `pin_data_o`
  - bit 5 drives `pin_led_o`
- R3: A command with bit 5 = 0 takes `pad_oe_o` to 0 one cycle after it is accepted. The pins take their new values one cycle later, so they never change while the pads are driven.
- R4: A command with bit 5 = 1 updates the pins one cycle after it is accepted. `pad_oe_o` rises one cycle after that.
- R5: A read command (`cmd_read` = 1) gives a one-cycle `rsp_valid` pulse three cycles after it is accepted, on either path. The inputs are sampled only after the new outputs are in place. `rsp_byte` bit 0 is `pin_din_i` and bit 1 is `pin_aux_i`.
- R6: `rsp_byte` bits 7 to 2 are always 0.
- R7: A write command (`cmd_read` = 0) never raises `rsp_valid`.
- R8: `cmd_ready` is 0 from the cycle after a command is accepted until the sequence ends. A `cmd_valid` offered while `cmd_ready` is 0 changes nothing.
- R9: With parameter `AS_MODE` = 0, `pin_ce_n_o` and `pin_cs_n_o` stay at 1 whatever the command.
- R10: Command bits 7 and 6 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_byte | input | 8 | Pin state word |
| cmd_read | input | 1 | 1 = also return the input pins |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_byte | output | 8 | Sampled inputs in bits 1:0 |
| pin_clk_o | output | 1 | Test clock pin |
| pin_mode_o | output | 1 | Mode select pin |
| pin_ce_n_o | output | 1 | Serial-flash chip enable, active low |
| pin_cs_n_o | output | 1 | Serial-flash chip select, active low |
| pin_data_o | output | 1 | Data out pin |
| pin_led_o | output | 1 | Indicator / enable line |
| pad_oe_o | output | 1 | Shared output pad enable |
| pin_din_i | input | 1 | Device data in pin |
| pin_aux_i | input | 1 | Serial-flash data in pin |

## Verification
The bench samples every cycle of each sequence to catch ordering faults:
- A design that moved the pins in the same cycle as it released the pads would show the new values while `pad_oe_o` is still high.
- A design that enabled the pads before loading the pins would show `pad_oe_o` high with the stale values.

A loopback run ties the data input to the data output pin. A design that sampled the inputs before applying the outputs would return the old level. Further runs offer a second command while the block is busy, set the two unused command bits, and build a variant with the serial-flash selects disabled. These catch a design that accepts commands too early, leaks unused bits onto the pins, or drives the selects when it should hold them high.

// File: rtl/pinport_pkg.sv
package pinport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PADS_OFF,
        ST_DRIVE,
        ST_PADS_ON,
        ST_CAPTURE
    } seq_state_t;

    // Bit order matches the command word: index 0 is the clock pin.
    typedef struct packed {
        logic en;
        logic data;
        logic cs_n;
        logic ce_n;
        logic mode;
        logic clk;
    } pin_vec_t;

    localparam int PIN_W = $bits(pin_vec_t);

endpackage

// File: rtl/pinport_seq.sv
module pinport_seq
    import pinport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_en,
    input  logic cmd_read,
    output logic cmd_ready,
    output logic take_cmd,
    output logic pads_off,
    output logic drive_pins,
    output logic pads_on,
    output logic capture
);

    seq_state_t state, state_nx;
    logic want_en, want_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            want_en <= 1'b0;
            want_rd <= 1'b0;
        end else begin
            state <= state_nx;
            if (take_cmd) begin
                want_en <= cmd_en;
                want_rd <= cmd_read;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (cmd_valid) state_nx = cmd_en ? ST_DRIVE : ST_PADS_OFF;
            ST_PADS_OFF: state_nx = ST_DRIVE;
            ST_DRIVE:    state_nx = want_en ? ST_PADS_ON : (want_rd ? ST_CAPTURE : ST_IDLE);
            ST_PADS_ON:  state_nx = want_rd ? ST_CAPTURE : ST_IDLE;
            ST_CAPTURE:  state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_ready  = (state == ST_IDLE);
        take_cmd   = (state == ST_IDLE) && cmd_valid;
        pads_off   = (state == ST_PADS_OFF);
        drive_pins = (state == ST_DRIVE);
        pads_on    = (state == ST_PADS_ON);
        capture    = (state == ST_CAPTURE);
    end

    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    a_r5_capture_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE) |=> (state == ST_IDLE));

endmodule

// File: rtl/pinport_pins.sv
module pinport_pins
    import pinport_pkg::*;
#(
    parameter bit AS_MODE = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  pin_vec_t next_pins,
    input  logic     pads_off,
    input  logic     pads_on,
    output pin_vec_t pins,
    output logic     pad_oe
);

    pin_vec_t pins_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= '0;
            pad_oe <= 1'b0;
        end else begin
            if (load)     pins_q <= next_pins;
            if (pads_off) pad_oe <= 1'b0;
            else if (pads_on) pad_oe <= 1'b1;
        end
    end

    assign pins.clk  = pins_q.clk;
    assign pins.mode = pins_q.mode;
    assign pins.data = pins_q.data;
    assign pins.en   = pins_q.en;

    generate
        if (AS_MODE) begin : g_sel_driven
            assign pins.ce_n = pins_q.ce_n;
            assign pins.cs_n = pins_q.cs_n;
        end else begin : g_sel_held
            logic unused_sel;
            assign unused_sel = pins_q.ce_n ^ pins_q.cs_n;
            assign pins.ce_n  = 1'b1;
            assign pins.cs_n  = 1'b1;
        end
    endgenerate

    a_r3_release_before_move: assert property (@(posedge clk) disable iff (!rst_n)
        ((pins_q != $past(pins_q)) && !pins_q.en) |-> !pad_oe);

    a_r3_fall_pins_still: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pad_oe) |-> $stable(pins_q));

    a_r4_rise_after_apply: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_oe) |-> ($stable(pins_q) && pins_q.en));

endmodule

// File: rtl/pinport_rdbk.sv
module pinport_rdbk #(
    parameter int RSP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             din,
    input  logic             aux,
    output logic             rsp_valid,
    output logic [RSP_W-1:0] rsp_byte
);

    localparam int PAD_W = RSP_W - 2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_byte  <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_byte <= {{PAD_W{1'b0}}, aux, din};
        end
    end

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_byte[RSP_W-1:2] == '0));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/pinport_top.sv
module pinport_top
    import pinport_pkg::*;
#(
    parameter bit AS_MODE = 1'b1,
    parameter int CMD_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [CMD_W-1:0] cmd_byte,
    input  logic             cmd_read,
    output logic             rsp_valid,
    output logic [CMD_W-1:0] rsp_byte,
    output logic             pin_clk_o,
    output logic             pin_mode_o,
    output logic             pin_ce_n_o,
    output logic             pin_cs_n_o,
    output logic             pin_data_o,
    output logic             pin_led_o,
    output logic             pad_oe_o,
    input  logic             pin_din_i,
    input  logic             pin_aux_i
);

    localparam int EN_BIT = PIN_W - 1;

    logic     take_cmd, pads_off, drive_pins, pads_on, capture;
    pin_vec_t cmd_q, pins;
    logic     unused_hi;

    assign unused_hi = ^cmd_byte[CMD_W-1:PIN_W];

    always_ff @(posedge clk) begin
        if (!rst_n)        cmd_q <= '0;
        else if (take_cmd) cmd_q <= pin_vec_t'(cmd_byte[PIN_W-1:0]);
    end

    pinport_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_en     (cmd_byte[EN_BIT]),
        .cmd_read   (cmd_read),
        .cmd_ready  (cmd_ready),
        .take_cmd   (take_cmd),
        .pads_off   (pads_off),
        .drive_pins (drive_pins),
        .pads_on    (pads_on),
        .capture    (capture)
    );

    pinport_pins #(.AS_MODE(AS_MODE)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (drive_pins),
        .next_pins (cmd_q),
        .pads_off  (pads_off),
        .pads_on   (pads_on),
        .pins      (pins),
        .pad_oe    (pad_oe_o)
    );

    pinport_rdbk #(.RSP_W(CMD_W)) u_rdbk (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .din       (pin_din_i),
        .aux       (pin_aux_i),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte)
    );

    assign pin_clk_o  = pins.clk;
    assign pin_mode_o = pins.mode;
    assign pin_ce_n_o = pins.ce_n;
    assign pin_cs_n_o = pins.cs_n;
    assign pin_data_o = pins.data;
    assign pin_led_o  = pins.en;

    a_r7_no_resp_for_write: assert property (@(posedge clk) disable iff (!rst_n)
        (take_cmd && !cmd_read) |=> !rsp_valid);

endmodule

// File: tb/sim_pinport_top.sv
module sim_pinport_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic cmd_read = 1'b0;
    logic din_val = 1'b0, aux_val = 1'b0, loop_en = 1'b0;
    logic cmd_ready, rsp_valid, pad_oe;
    logic [7:0] rsp_byte;
    logic p_clk, p_mode, p_ce, p_cs, p_data, p_led, din_w;
    logic v_ready, v_rv, v_clk, v_mode, v_ce, v_cs, v_data, v_led, v_oe;
    logic [7:0] v_rb;

    int total = 0, bad = 0;
    logic [5:0] tr_pins [0:4];
    logic       tr_oe   [0:4];
    logic       tr_rv   [0:4];
    logic [7:0] tr_rb   [0:4];
    logic       tr_rdy  [0:4];

    always #5 clk = ~clk;

    assign din_w = loop_en ? p_data : din_val;

    pinport_top u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_byte(cmd_byte), .cmd_read(cmd_read), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .pin_clk_o(p_clk), .pin_mode_o(p_mode), .pin_ce_n_o(p_ce), .pin_cs_n_o(p_cs),
        .pin_data_o(p_data), .pin_led_o(p_led), .pad_oe_o(pad_oe),
        .pin_din_i(din_w), .pin_aux_i(aux_val)
    );

    pinport_top #(.AS_MODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(v_ready),
        .cmd_byte(cmd_byte), .cmd_read(cmd_read), .rsp_valid(v_rv), .rsp_byte(v_rb),
        .pin_clk_o(v_clk), .pin_mode_o(v_mode), .pin_ce_n_o(v_ce), .pin_cs_n_o(v_cs),
        .pin_data_o(v_data), .pin_led_o(v_led), .pad_oe_o(v_oe),
        .pin_din_i(din_val), .pin_aux_i(aux_val)
    );

    function automatic logic [5:0] pinvec();
        return {p_led, p_data, p_cs, p_ce, p_mode, p_clk};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one command, record outputs at the negedge after edges E0..E4.
    task automatic issue(input logic [7:0] b, input logic rd, input logic [7:0] busy_b, input bit offer_busy);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_byte = b; cmd_read = rd;
        @(posedge clk);
        @(negedge clk);
        if (offer_busy) begin cmd_byte = busy_b; cmd_read = 1'b1; end
        else cmd_valid = 1'b0;
        tr_pins[0] = pinvec(); tr_oe[0] = pad_oe; tr_rv[0] = rsp_valid;
        tr_rb[0] = rsp_byte; tr_rdy[0] = cmd_ready;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 1) cmd_valid = 1'b0;
            tr_pins[k] = pinvec(); tr_oe[k] = pad_oe; tr_rv[k] = rsp_valid;
            tr_rb[k] = rsp_byte; tr_rdy[k] = cmd_ready;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(pinvec() == 6'h00, "R1 pins", pinvec(), 0);
        check(pad_oe == 1'b0, "R1 pad_oe", pad_oe, 0);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
        check({v_ce, v_cs} == 2'b11, "R9 selects after reset", {v_ce, v_cs}, 3);
    endtask

    task automatic t_enable_write();
        issue(8'h3F, 1'b0, 8'h00, 1'b0);
        check(tr_pins[1] == 6'h3F, "R4 pins after E1", tr_pins[1], 6'h3F);
        check(tr_oe[1] == 1'b0, "R4 pads still off at E1", tr_oe[1], 0);
        check(tr_oe[2] == 1'b1, "R4 pads on at E2", tr_oe[2], 1);
        check(!(tr_rv[1] | tr_rv[2] | tr_rv[3] | tr_rv[4]), "R7 no response", tr_rv[3], 0);
        check({v_ce, v_cs} == 2'b11, "R9 selects held", {v_ce, v_cs}, 3);
    endtask

    task automatic t_disable_write();
        issue(8'h12, 1'b0, 8'h00, 1'b0);
        check(tr_oe[1] == 1'b0, "R3 pads off at E1", tr_oe[1], 0);
        check(tr_pins[1] == 6'h3F, "R3 pins unchanged at E1", tr_pins[1], 6'h3F);
        check(tr_pins[2] == 6'h12, "R3 pins at E2", tr_pins[2], 6'h12);
        check(tr_oe[2] == 1'b0, "R3 pads stay off", tr_oe[2], 0);
        check(tr_rv[3] == 1'b0, "R7 no response", tr_rv[3], 0);
    endtask

    task automatic t_mapping();
        for (int i = 0; i < 5; i++) begin
            issue(8'h20 | (8'h01 << i), 1'b0, 8'h00, 1'b0);
            check(tr_pins[1] == (6'h20 | (6'h01 << i)), "R2 bit map", tr_pins[1], 6'h20 | (6'h01 << i));
            check({v_ce, v_cs} == 2'b11, "R9 selects held", {v_ce, v_cs}, 3);
        end
    endtask

    task automatic t_read();
        din_val = 1'b1; aux_val = 1'b0;
        issue(8'h21, 1'b1, 8'h00, 1'b0);
        check(tr_rv[2] == 1'b0, "R5 no early pulse", tr_rv[2], 0);
        check(tr_rv[3] == 1'b1, "R5 pulse at E3 (on path)", tr_rv[3], 1);
        check(tr_rb[3] == 8'h01, "R5 din in bit0", tr_rb[3], 8'h01);
        check(tr_rv[4] == 1'b0, "R5 single pulse", tr_rv[4], 0);
        din_val = 1'b0; aux_val = 1'b1;
        issue(8'h04, 1'b1, 8'h00, 1'b0);
        check(tr_rv[3] == 1'b1, "R5 pulse at E3 (off path)", tr_rv[3], 1);
        check(tr_rb[3] == 8'h02, "R5 aux in bit1", tr_rb[3], 8'h02);
        din_val = 1'b1; aux_val = 1'b1;
        issue(8'h3F, 1'b1, 8'h00, 1'b0);
        check(tr_rb[3] == 8'h03, "R6 upper bits zero", tr_rb[3], 8'h03);
    endtask

    task automatic t_loopback();
        issue(8'h20, 1'b0, 8'h00, 1'b0);
        loop_en = 1'b1;
        issue(8'h30, 1'b1, 8'h00, 1'b0);
        check(tr_rb[3][0] == 1'b1, "R5 sample after apply (rise)", tr_rb[3], 1);
        issue(8'h00, 1'b1, 8'h00, 1'b0);
        check(tr_rb[3][0] == 1'b0, "R5 sample after apply (fall)", tr_rb[3], 0);
        loop_en = 1'b0;
    endtask

    task automatic t_upper_bits();
        issue(8'hE5, 1'b0, 8'h00, 1'b0);
        check(tr_pins[1] == 6'h25, "R10 bits 7:6 ignored", tr_pins[1], 6'h25);
        issue(8'hC0, 1'b1, 8'h00, 1'b0);
        check(tr_pins[2] == 6'h00, "R10 bits 7:6 ignored (off)", tr_pins[2], 0);
        check(tr_oe[2] == 1'b0, "R10 no enable from bits 7:6", tr_oe[2], 0);
    endtask

    task automatic t_busy();
        issue(8'h2A, 1'b0, 8'h15, 1'b1);
        check(tr_rdy[0] == 1'b0, "R8 ready low after accept", tr_rdy[0], 0);
        check(tr_rdy[1] == 1'b0, "R8 ready low mid-sequence", tr_rdy[1], 0);
        check(tr_pins[4] == 6'h2A, "R8 busy offer ignored", tr_pins[4], 6'h2A);
        check(tr_oe[4] == 1'b1, "R8 pads follow first command", tr_oe[4], 1);
        check(!(tr_rv[3] | tr_rv[4]), "R8 no response from busy offer", tr_rv[4], 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable_write();
        t_disable_write();
        t_mapping();
        t_read();
        t_loopback();
        t_upper_bits();
        t_busy();
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule